// File: doc/BRIEF.md
# Sub-expression sharing constant multiplier

This block scales a stream of 16-bit signed samples by a 17-bit signed gain held in a writable register. The result is a 16-bit signed value equal to the product divided by 2^16, truncated toward zero. Both operands are first reduced to a sign and a magnitude. The 16-bit gain magnitude is cut into eight 2-bit digits. Each digit picks one of four precomputed multiples of the sample magnitude: zero, once, twice or three times. A three-layer pipelined adder tree then folds these partial products pairwise.

An equality checker watches the stored gain. It raises seven reuse flags: one per nibble whose two digits match, one per byte whose two nibbles match, and one when the two bytes match. When a flag is set, the adder at that tree position feeds its low operand into both inputs, one copy shifted. It does not read the twin operand. The flags travel down the pipeline with the sample, so a gain change never corrupts a sample already in flight. The sign, the XOR of the two operand signs, is applied again to the truncated magnitude at the output.

Top module: `vh_const_mult`

## Requirements
- R1: With x the signed 16-bit sample and c the signed 17-bit stored gain, y_out equals the product x*c with its magnitude divided by 65536 and truncated toward zero, carrying the sign of the product.
- R2: A sample accepted on a rising edge with in_valid high sets out_valid, and its y_out, after the fourth rising edge counting the accepting one. Samples on consecutive edges give results on consecutive cycles, and out_valid is low in every other cycle.
- R3: A stored gain of -65536 acts as -65535, since the gain magnitude is limited to 16 bits.
- R4: coef_we high on a rising edge loads coef_wdata. A sample accepted on that same edge still uses the previous gain, and samples from the next edge on use the new one.
- R5: After reset the stored gain is 0, out_valid is low and y_out is 0, so samples taken before any write give 0.
- R6: Negative operands are handled, including a sample of -32768. A product whose magnitude is below 65536 gives 0, never -1.
- R7: Gain magnitude bits [4k+1:4k] and [4k+3:4k+2] matching (k = 0..3), bits [8j+3:8j] and [8j+7:8j+4] matching (j = 0..1), and bits [7:0] and [15:8] matching each switch on operand reuse at that adder. The result stays as in R1.
- R8: While out_valid is low, y_out holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_we | input | 1 | Load coef_wdata into the gain register |
| coef_wdata | input | 17 | Signed gain to store |
| in_valid | input | 1 | x_in carries a sample this cycle |
| x_in | input | 16 | Signed sample |
| out_valid | output | 1 | y_out carries a new result |
| y_out | output | 16 | Signed scaled result |

## Verification
A gain write and a sample acceptance can land on the same rising edge. That edge decides which gain the sample sees, and the reuse flags captured for it must belong to the old gain while the next sample picks up the new one. The bench provokes this by driving coef_we and in_valid in the same cycle, both in a directed pair and throughout a random stream. Each result is then compared, cycle by cycle, with a reference model that applies the write only after computing the colliding sample's product.

// File: rtl/vh_pkg.sv
package vh_pkg;
  // Width of one coefficient digit that selects a partial product
  localparam int GROUP_W = 2;

  typedef logic [GROUP_W-1:0] digit_t;

  // Meaning of a digit value: which multiple of the sample it selects
  typedef enum logic [GROUP_W-1:0] {
    PP_ZERO   = 2'd0,
    PP_ONCE   = 2'd1,
    PP_TWICE  = 2'd2,
    PP_THRICE = 2'd3
  } pp_sel_e;
endpackage

// File: rtl/vh_coef_store.sv
module vh_coef_store #(
  parameter int COEF_W = 17,
  parameter int MAG_W  = COEF_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [COEF_W-1:0] wr_data,
  output logic              coef_sign,
  output logic [MAG_W-1:0]  coef_mag,
  output logic [MAG_W/vh_pkg::GROUP_W-2:0] reuse_flags
);
  localparam int GW     = vh_pkg::GROUP_W;
  localparam int NG     = MAG_W / GW;
  localparam int L1_N   = NG / 2;
  localparam int L2_N   = NG / 4;
  localparam int L3_N   = NG / 8;
  localparam int L2_OFS = L1_N;
  localparam int L3_OFS = L1_N + L2_N;

  logic [COEF_W-1:0] coef_q;

  // Magnitude of the stored gain, limited to MAG_W bits
  function automatic logic [MAG_W-1:0] f_gain_mag(input logic [COEF_W-1:0] c);
    logic [COEF_W-1:0] full;
    full = c[COEF_W-1] ? (~c + 1'b1) : c;
    return full[COEF_W-1] ? '1 : full[MAG_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     coef_q <= '0;
    else if (wr_en) coef_q <= wr_data;
  end

  assign coef_sign = coef_q[COEF_W-1];
  assign coef_mag  = f_gain_mag(coef_q);

  // Equality checks: digit pairs, nibble pairs, byte halves
  for (genvar k = 0; k < L1_N; k++) begin : g_eq_l1
    assign reuse_flags[k] =
      coef_mag[(2*k)*GW +: GW] == coef_mag[(2*k+1)*GW +: GW];
  end
  for (genvar j = 0; j < L2_N; j++) begin : g_eq_l2
    assign reuse_flags[L2_OFS+j] =
      coef_mag[(2*j)*2*GW +: 2*GW] == coef_mag[(2*j+1)*2*GW +: 2*GW];
  end
  for (genvar h = 0; h < L3_N; h++) begin : g_eq_l3
    assign reuse_flags[L3_OFS+h] =
      coef_mag[(2*h)*4*GW +: 4*GW] == coef_mag[(2*h+1)*4*GW +: 4*GW];
  end

  // R4
  write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (coef_q == $past(wr_data)));
  // R4
  hold_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(coef_q));
endmodule

// File: rtl/vh_pp_stage.sv
module vh_pp_stage #(
  parameter int DATA_W = 16,
  parameter int MAG_W  = 16,
  parameter int PP_W   = DATA_W + 1,
  parameter int NF     = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    x_in,
  input  logic                 coef_sign,
  input  logic [MAG_W-1:0]     coef_mag,
  input  logic [NF-1:0]        flags_in,
  output logic                 v_q,
  output logic                 sign_q,
  output logic [NF-1:0]        flags_q,
  output logic [(MAG_W/vh_pkg::GROUP_W)*PP_W-1:0] pp_q
);
  localparam int GW = vh_pkg::GROUP_W;
  localparam int NG = MAG_W / GW;

  // Magnitude of a two's complement sample (the most negative value fits)
  function automatic logic [DATA_W-1:0] f_sample_mag(input logic [DATA_W-1:0] v);
    return v[DATA_W-1] ? (~v + 1'b1) : v;
  endfunction

  // Partial product chosen by one digit
  function automatic logic [PP_W-1:0] f_pick(input vh_pkg::digit_t d,
                                             input logic [PP_W-1:0] m1,
                                             input logic [PP_W-1:0] m2,
                                             input logic [PP_W-1:0] m3);
    case (vh_pkg::pp_sel_e'(d))
      vh_pkg::PP_ONCE:   return m1;
      vh_pkg::PP_TWICE:  return m2;
      vh_pkg::PP_THRICE: return m3;
      default:           return '0;
    endcase
  endfunction

  logic [DATA_W-1:0]       x_mag;
  logic [PP_W-1:0]         mul1, mul2, mul3;
  logic [NG*PP_W-1:0]      pp_next;
  logic                    sign_next;

  assign x_mag     = f_sample_mag(x_in);
  assign mul1      = PP_W'(x_mag);
  assign mul2      = PP_W'({x_mag, 1'b0});
  assign mul3      = mul1 + mul2;
  assign sign_next = x_in[DATA_W-1] ^ coef_sign;

  always_comb begin
    for (int g = 0; g < NG; g++)
      pp_next[g*PP_W +: PP_W] = f_pick(coef_mag[g*GW +: GW], mul1, mul2, mul3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      sign_q  <= 1'b0;
      flags_q <= '0;
      pp_q    <= '0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        sign_q  <= sign_next;
        flags_q <= flags_in;
        pp_q    <= pp_next;
      end
    end
  end

  // R1
  zero_pp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && x_in == '0) |=> (pp_q == '0));
endmodule

// File: rtl/vh_pair_adder.sv
module vh_pair_adder #(
  parameter int N_IN  = 8,
  parameter int IN_W  = 17,
  parameter int SHIFT = 2,
  parameter int SB_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [N_IN*IN_W-1:0]            opnd,
  input  logic [N_IN/2-1:0]               reuse,
  input  logic [SB_W-1:0]                 sb_in,
  output logic                            out_valid,
  output logic [(N_IN/2)*(IN_W+SHIFT)-1:0] sum_q,
  output logic [SB_W-1:0]                 sb_out
);
  localparam int N_OUT = N_IN / 2;
  localparam int OUT_W = IN_W + SHIFT;

  // Low operand plus the shifted high operand
  function automatic logic [OUT_W-1:0] f_pair(input logic [IN_W-1:0] lo,
                                              input logic [IN_W-1:0] hi);
    return {{SHIFT{1'b0}}, lo} + {hi, {SHIFT{1'b0}}};
  endfunction

  logic [N_OUT*OUT_W-1:0] sum_next;

  for (genvar k = 0; k < N_OUT; k++) begin : g_pair
    logic [IN_W-1:0] lo_op, hi_op, twin_op;
    assign lo_op   = opnd[(2*k)*IN_W +: IN_W];
    assign hi_op   = opnd[(2*k+1)*IN_W +: IN_W];
    // Reuse: the low operand stands in for its twin
    assign twin_op = reuse[k] ? lo_op : hi_op;
    assign sum_next[k*OUT_W +: OUT_W] = f_pair(lo_op, twin_op);

    // R7
    reuse_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && reuse[k]) |-> (lo_op == hi_op));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum_q     <= '0;
      sb_out    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum_q  <= sum_next;
        sb_out <= sb_in;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
endmodule

// File: rtl/vh_const_mult.sv
module vh_const_mult #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coef_we,
  input  logic [COEF_W-1:0] coef_wdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] x_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] y_out
);
  localparam int GW     = vh_pkg::GROUP_W;
  localparam int MAG_W  = COEF_W - 1;
  localparam int NG     = MAG_W / GW;
  localparam int NF     = NG - 1;
  localparam int L1_N   = NG / 2;
  localparam int L2_N   = NG / 4;
  localparam int PP_W   = DATA_W + GW - 1;
  localparam int S2_W   = PP_W + GW;
  localparam int S3_W   = S2_W + 2*GW;
  localparam int PROD_W = S3_W + 4*GW;
  localparam int FRAC_W = MAG_W;
  localparam int KEEP_W = PROD_W - FRAC_W;

  // Reapply the sign to the truncated magnitude
  function automatic logic [DATA_W-1:0] f_signed_out(input logic neg,
                                                     input logic [KEEP_W-1:0] m);
    logic [DATA_W-1:0] e;
    e = DATA_W'(m);
    return neg ? (~e + 1'b1) : e;
  endfunction

  logic               c_sign;
  logic [MAG_W-1:0]   c_mag;
  logic [NF-1:0]      c_flags;

  logic               v1, sign1;
  logic [NF-1:0]      flags1;
  logic [NG*PP_W-1:0] pp1;

  logic               v2;
  logic [L1_N*S2_W-1:0] sum2;
  logic [NF-L1_N:0]   sb2;

  logic               v3;
  logic [L2_N*S3_W-1:0] sum3;
  logic [NF-L1_N-L2_N:0] sb3;

  logic               v4;
  logic [PROD_W-1:0]  total;
  logic [0:0]         sb4;

  vh_coef_store #(.COEF_W(COEF_W), .MAG_W(MAG_W)) u_coef (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_data(coef_wdata),
    .coef_sign(c_sign), .coef_mag(c_mag), .reuse_flags(c_flags)
  );

  vh_pp_stage #(.DATA_W(DATA_W), .MAG_W(MAG_W), .PP_W(PP_W), .NF(NF)) u_pp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in),
    .coef_sign(c_sign), .coef_mag(c_mag), .flags_in(c_flags),
    .v_q(v1), .sign_q(sign1), .flags_q(flags1), .pp_q(pp1)
  );

  // Layer 2: digit pairs
  vh_pair_adder #(.N_IN(NG), .IN_W(PP_W), .SHIFT(GW), .SB_W(NF-L1_N+1)) u_l2 (
    .clk(clk), .rst_n(rst_n), .in_valid(v1), .opnd(pp1),
    .reuse(flags1[L1_N-1:0]), .sb_in({sign1, flags1[NF-1:L1_N]}),
    .out_valid(v2), .sum_q(sum2), .sb_out(sb2)
  );

  // Layer 3: nibble pairs
  vh_pair_adder #(.N_IN(L1_N), .IN_W(S2_W), .SHIFT(2*GW), .SB_W(NF-L1_N-L2_N+1)) u_l3 (
    .clk(clk), .rst_n(rst_n), .in_valid(v2), .opnd(sum2),
    .reuse(sb2[L2_N-1:0]), .sb_in(sb2[NF-L1_N:L2_N]),
    .out_valid(v3), .sum_q(sum3), .sb_out(sb3)
  );

  // Layer 4: byte halves
  vh_pair_adder #(.N_IN(L2_N), .IN_W(S3_W), .SHIFT(4*GW), .SB_W(1)) u_l4 (
    .clk(clk), .rst_n(rst_n), .in_valid(v3), .opnd(sum3),
    .reuse(sb3[0:0]), .sb_in(sb3[NF-L1_N-L2_N:1]),
    .out_valid(v4), .sum_q(total), .sb_out(sb4)
  );

  assign out_valid = v4;
  assign y_out     = f_signed_out(sb4[0], total[PROD_W-1:FRAC_W]);

  // R6
  small_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (total < (PROD_W'(1) << FRAC_W))) |-> (y_out == '0));
  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(y_out));
endmodule

// File: tb/vh_const_mult_test.sv
module vh_const_mult_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        coef_we;
  logic [16:0] coef_wdata;
  logic        in_valid;
  logic [15:0] x_in;
  logic        out_valid;
  logic [15:0] y_out;

  int    n_total = 0;
  int    n_fail  = 0;
  bit    chk_on  = 1'b0;
  bit    done    = 1'b0;
  string cur_tag = "R2";

  // reference model state
  int    m_coef = 0;
  bit    qv[$];
  int    qy[$];
  string qt[$];
  bit    e_valid = 1'b0;
  int    e_y     = 0;
  string e_tag   = "R5";

  always #4 clk = ~clk;

  vh_const_mult uut (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_wdata(coef_wdata),
    .in_valid(in_valid), .x_in(x_in), .out_valid(out_valid), .y_out(y_out)
  );

  function automatic int ref_product(input int x, input int c);
    longint p, m, t;
    p = longint'(x) * longint'(c);
    m = (p < 0) ? -p : p;
    t = m / 65536;
    return int'((p < 0) ? -t : t);
  endfunction

  function automatic int clamp_gain(input int c);
    return (c < -65535) ? -65535 : c;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_total++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  // Model: computes with the gain held before any same-edge write
  always @(posedge clk) begin
    if (!rst_n) begin
      m_coef = 0;
      qv.delete(); qy.delete(); qt.delete();
      for (int i = 0; i < 4; i++) begin
        qv.push_back(1'b0); qy.push_back(0); qt.push_back("R5");
      end
      e_valid = 1'b0;
      e_y     = 0;
    end else begin
      qv.push_front(in_valid);
      qy.push_front(in_valid ? ref_product(int'($signed(x_in)), m_coef) : 0);
      qt.push_front(cur_tag);
      void'(qv.pop_back()); void'(qy.pop_back()); void'(qt.pop_back());
      e_valid = qv[3];
      if (qv[3]) begin
        e_y   = qy[3];
        e_tag = qt[3];
      end
      if (coef_we) m_coef = clamp_gain(int'($signed(coef_wdata)));
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && chk_on && !done) begin
      check("R2", int'(out_valid), int'(e_valid));
      check(e_valid ? e_tag : "R8", int'($signed(y_out)), e_y);
    end
  end

  task automatic drive(input bit v, input int x, input bit we, input int c,
                       input string tag);
    @(negedge clk);
    in_valid   = v;
    x_in       = x[15:0];
    coef_we    = we;
    coef_wdata = c[16:0];
    cur_tag    = tag;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; x_in = '0; coef_we = 1'b0; coef_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R5: reset state
    check("R5", int'(out_valid), 0);
    check("R5", int'(y_out), 0);
    chk_on = 1'b1;

    // R5: gain is zero before any write
    drive(1, 12345, 0, 0, "R5");
    drive(1, -32768, 0, 0, "R5");

    // R7: every digit, nibble and byte repeats
    drive(0, 0, 1, 21845, "R7");
    drive(1, 32767, 0, 0, "R7");
    drive(1, -32768, 0, 0, "R7");
    drive(1, 1, 0, 0, "R7");
    drive(1, -1, 0, 0, "R7");
    drive(1, 1000, 0, 0, "R7");
    // R7: nibbles repeat but bytes differ
    drive(0, 0, 1, 255, "R7");
    drive(1, -7777, 0, 0, "R7");
    drive(1, 30000, 0, 0, "R7");
    // R7: negative repeating gain
    drive(0, 0, 1, -13107, "R7");
    drive(1, 22222, 0, 0, "R7");
    drive(1, -22222, 0, 0, "R7");

    // R1: no repeated groups
    drive(0, 0, 1, 4660, "R1");
    drive(1, 32767, 0, 0, "R1");
    drive(1, -12345, 0, 0, "R1");
    drive(0, 0, 1, 59201, "R1");
    drive(1, 25000, 0, 0, "R1");

    // R6: negative operands and tiny products
    drive(0, 0, 1, -30001, "R6");
    drive(1, -32768, 0, 0, "R6");
    drive(1, 17, 0, 0, "R6");
    drive(0, 0, 1, 1, "R6");
    drive(1, -1, 0, 0, "R6");
    drive(1, 32767, 0, 0, "R6");
    drive(0, 0, 1, -3, "R6");
    drive(1, 30000, 0, 0, "R6");

    // R3: most negative gain
    drive(0, 0, 1, -65536, "R3");
    drive(1, 32767, 0, 0, "R3");
    drive(1, -32768, 0, 0, "R3");
    drive(1, -1, 0, 0, "R3");

    // R4: write and sample on the same edge, then the next sample
    drive(1, 20000, 1, 40000, "R4");
    drive(1, 20000, 0, 0, "R4");
    drive(1, -20000, 1, -21846, "R4");
    drive(1, -20000, 0, 0, "R4");

    // R8: idle gap holds the last result
    for (int i = 0; i < 6; i++) drive(0, 555, 0, 0, "R8");
    drive(1, 4321, 0, 0, "R8");
    for (int i = 0; i < 6; i++) drive(0, -555, 0, 0, "R8");

    // R2: back-to-back stream with occasional gain writes
    for (int i = 0; i < 400; i++) begin
      int  xv, cv;
      bit  vv, wv;
      xv = int'($urandom_range(65535)) - 32768;
      cv = int'($urandom_range(131071)) - 65536;
      if ($urandom_range(3) == 0) cv = 21845 * ($urandom_range(1) == 0 ? 1 : -2);
      vv = ($urandom_range(9) != 0);
      wv = ($urandom_range(7) == 0);
      drive(vv, xv, wv, cv, "R2");
    end

    for (int i = 0; i < 8; i++) drive(0, 0, 0, 0, "R8");
    done = 1'b1;
    finish_run();
  end
endmodule